// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the control side of a receive DMA engine that walks a ring of descriptors in host memory. It reads word 0 of each descriptor through a one-request, one-response read port, checks which side owns it, and tells the frame datapath whether each arriving frame may be stored or must be thrown away. When a frame or a buffer is used up, it issues a close request carrying a status word and steps to the next descriptor in the ring.

The controller always tries to hold one DMA-owned descriptor ahead of the next frame, so a frame that arrives while a descriptor is held is accepted without a memory read. If the ring runs dry it enters a suspended state and raises a sticky buffer-unavailable flag once. Each later frame makes it read the same descriptor again: the frame is accepted if the host has since given that descriptor back, and dropped if not. A poll demand resumes a suspended engine at the same ring position. Clearing the start control stops the engine, after any frame in progress has finished.

Top module: `rxring_ctrl`

## Requirements
- R1: After reset, run_state is 0 (stopped), flags are 0 and no read, close, accept or drop pulse is issued.
- R2: When cfg_start is high in the stopped state, rd_req pulses for exactly one cycle in the following cycle, with rd_addr equal to cfg_base.
- R3: A descriptor whose word 0 bit 31 is 1 is owned by the DMA and is held, with run_state 1 (running). If bit 31 is 0 the engine suspends (run_state 2) and sets flags bit 0 (buffer unavailable).
- R4: A frm_start pulse while a descriptor is held gives a one-cycle frm_accept pulse in the next cycle and no read request.
- R5: A frm_done pulse during a frame gives, in the next cycle, a one-cycle cls_req with cls_addr equal to the descriptor address, cls_status bit 31 equal to 0, bit 30 a copy of the descriptor's word 0 bit 30, and bits 29:0 equal to frm_status. If cfg_start is high, a fetch of the next descriptor is issued in the same cycle.
- R6: The next descriptor address is the current address plus DESC_BYTES, or cfg_base when the closed descriptor's word 0 bit 30 (ring end) is 1.
- R7: frm_buf_end during a frame closes the current descriptor and fetches the next. If that descriptor is DMA-owned, the frame continues with run_state 1 and no accept pulse. If it is host-owned, frm_drop pulses, the engine suspends, and flags bits 0 and 1 are set.
- R8: A frm_start in the suspended state causes a read of the same descriptor address. If that descriptor is DMA-owned, frm_accept pulses after the response. If not, frm_drop pulses, flags bit 1 (frame discarded) is set and the engine stays suspended.
- R9: Buffer unavailable (flags bit 0) is set only on a transition from running to suspended, never on a discard made while already suspended.
- R10: poll_demand in the suspended state re-reads the same descriptor and resumes running if it is DMA-owned. In any other state it has no effect.
- R11: With cfg_start low, the engine goes to stopped from a held or suspended state, and after frm_done of the current frame; that final close issues no fetch. A later start fetches from cfg_base.
- R12: Flags are sticky; writing 1 to a flag_clr bit clears that flag in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Receive enable level |
| cfg_base | input | AW | Byte address of the first ring descriptor |
| poll_demand | input | 1 | Pulse: re-check the current descriptor |
| frm_start | input | 1 | Pulse: a new frame begins |
| frm_buf_end | input | 1 | Pulse: buffer filled before the frame ended |
| frm_done | input | 1 | Pulse: frame complete |
| frm_status | input | 30 | Status stored into the closed descriptor |
| frm_accept | output | 1 | Pulse: store the new frame |
| frm_drop | output | 1 | Pulse: discard the current frame |
| rd_req | output | 1 | Pulse: read descriptor word 0 |
| rd_addr | output | AW | Descriptor read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Descriptor word 0 |
| cls_req | output | 1 | Pulse: close descriptor |
| cls_addr | output | AW | Address of descriptor being closed |
| cls_status | output | 32 | Word 0 written on close |
| flag_clr | input | 2 | Write-one-to-clear for flags |
| flags | output | 2 | Bit 0 buffer unavailable, bit 1 frame discarded |
| run_state | output | 2 | 0 stopped, 1 running, 2 suspended |

## Verification
Every pulse output reacts one clock after the input or read response that causes it. A read therefore appears the cycle after start, frame end or poll. An accept or drop appears the cycle after rd_valid, or the cycle after frm_start when a descriptor is held, and a flag falls the cycle after its clear bit. The bench's reference model updates on each rising edge from the inputs it has just driven, and the outputs are compared with its predictions on the following falling edge, so every comparison falls exactly in the cycle where the result is due. The memory responder replies two cycles after each request, so the latency between a fetch and the resulting decision is exercised.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
   localparam int OWN_BIT      = 31;
   localparam int RING_END_BIT = 30;
   localparam int STAT_W       = RING_END_BIT;
   localparam int NFLAG        = 2;

   typedef enum logic [2:0] {
      PH_STOP, PH_FETCH, PH_HOLD, PH_BUSY, PH_SUSP
   } rx_phase_e;

   typedef enum logic [1:0] {
      RS_STOPPED   = 2'd0,
      RS_RUNNING   = 2'd1,
      RS_SUSPENDED = 2'd2
   } run_state_e;
endpackage

// File: rtl/rxring_addr.sv
module rxring_addr #(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base,
   input  logic          load_base,
   input  logic          advance,
   input  logic          ring_end,
   output logic [AW-1:0] cur_addr
);
   localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

   if (DESC_BYTES < 4 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_step
      $error("rxring_addr: DESC_BYTES must be a power of two of at least 4");
   end
   if (AW < 8) begin : g_bad_aw
      $error("rxring_addr: AW must be at least 8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cur_addr <= '0;
      else if (load_base) cur_addr <= base;
      else if (advance)   cur_addr <= ring_end ? base : cur_addr + STEP;
   end

   assert_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !ring_end && !load_base) |=> cur_addr == $past(cur_addr) + STEP);
   assert_wrap_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && ring_end && !load_base) |=> cur_addr == $past(base));
endmodule

// File: rtl/rxring_flags.sv
module rxring_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clr[i]) flags[i] <= 1'b0;
      end

      assert_w1c_R12 : assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);
      assert_sticky_R12 : assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr[i]) |=> flags[i]);
   end
endmodule

// File: rtl/rxring_fsm.sv
module rxring_fsm
   import rxring_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start,
   input  logic              poll_demand,
   input  logic              frm_start,
   input  logic              frm_buf_end,
   input  logic              frm_done,
   input  logic [STAT_W-1:0] frm_status,
   input  logic              rd_valid,
   input  logic              desc_own,
   input  logic              desc_end,
   input  logic [AW-1:0]     cur_addr,
   output logic              load_base,
   output logic              advance,
   output logic              ring_end,
   output logic              set_rbu,
   output logic              set_drop,
   output logic              rd_req,
   output logic              frm_accept,
   output logic              frm_drop,
   output logic              cls_req,
   output logic [AW-1:0]     cls_addr,
   output logic [31:0]       cls_status,
   output logic [1:0]        run_state
);
   rx_phase_e ph_q, ph_d;
   logic pend_q, pend_d, mid_q, mid_d, fs_q, fs_d, end_d;
   logic rdreq_d, acc_d, drop_d, cls_d;

   always_comb begin
      ph_d = ph_q;  pend_d = pend_q;  mid_d = mid_q;  fs_d = fs_q;  end_d = ring_end;
      rdreq_d = 1'b0;  acc_d = 1'b0;  drop_d = 1'b0;  cls_d = 1'b0;
      set_rbu = 1'b0;  set_drop = 1'b0;  load_base = 1'b0;  advance = 1'b0;
      unique case (ph_q)
         PH_STOP: if (cfg_start) begin
            load_base = 1'b1;  rdreq_d = 1'b1;  ph_d = PH_FETCH;
            pend_d = 1'b0;  mid_d = 1'b0;  fs_d = 1'b0;
         end
         PH_FETCH: begin
            if (frm_start) pend_d = 1'b1;
            if (rd_valid) begin
               end_d = desc_end;
               if (desc_own) begin
                  if (mid_q)       ph_d = PH_BUSY;
                  else if (pend_d) begin acc_d = 1'b1; ph_d = PH_BUSY; end
                  else             ph_d = PH_HOLD;
               end else begin
                  set_rbu = !fs_q;
                  if (pend_d || mid_q) begin drop_d = 1'b1; set_drop = 1'b1; end
                  ph_d = PH_SUSP;
               end
               pend_d = 1'b0;
            end
         end
         PH_HOLD:
            if (frm_start)       begin acc_d = 1'b1; ph_d = PH_BUSY; end
            else if (!cfg_start) ph_d = PH_STOP;
         PH_BUSY:
            if (frm_done || frm_buf_end) begin
               cls_d = 1'b1;  advance = 1'b1;  pend_d = 1'b0;  fs_d = 1'b0;
               mid_d = !frm_done;
               if (!frm_done || cfg_start) begin rdreq_d = 1'b1; ph_d = PH_FETCH; end
               else ph_d = PH_STOP;
            end
         PH_SUSP:
            if (frm_start || poll_demand) begin
               rdreq_d = 1'b1;  ph_d = PH_FETCH;  fs_d = 1'b1;
               pend_d = frm_start;  mid_d = 1'b0;
            end else if (!cfg_start) ph_d = PH_STOP;
         default: ph_d = PH_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_STOP;  pend_q <= 1'b0;  mid_q <= 1'b0;  fs_q <= 1'b0;  ring_end <= 1'b0;
         rd_req <= 1'b0;  frm_accept <= 1'b0;  frm_drop <= 1'b0;  cls_req <= 1'b0;
         cls_addr <= '0;  cls_status <= '0;
      end else begin
         ph_q <= ph_d;  pend_q <= pend_d;  mid_q <= mid_d;  fs_q <= fs_d;  ring_end <= end_d;
         rd_req <= rdreq_d;  frm_accept <= acc_d;  frm_drop <= drop_d;  cls_req <= cls_d;
         if (cls_d) begin
            cls_addr   <= cur_addr;
            cls_status <= {1'b0, ring_end, frm_status};
         end
      end
   end

   always_comb begin
      if (ph_q == PH_STOP)                            run_state = RS_STOPPED;
      else if (ph_q == PH_SUSP || (ph_q == PH_FETCH && fs_q)) run_state = RS_SUSPENDED;
      else                                            run_state = RS_RUNNING;
   end

   assert_req_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   assert_one_verdict_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(frm_accept && frm_drop));
   assert_refetch_same_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_SUSP && frm_start) |=> (rd_req && cur_addr == $past(cur_addr)));
   assert_stop_no_fetch_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_STOP && !cfg_start) |=> !rd_req);
   assert_hold_no_fetch_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_HOLD && frm_start) |=> (frm_accept && !rd_req));
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
   import rxring_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_start,
   input  logic [AW-1:0]     cfg_base,
   input  logic              poll_demand,
   input  logic              frm_start,
   input  logic              frm_buf_end,
   input  logic              frm_done,
   input  logic [STAT_W-1:0] frm_status,
   output logic              frm_accept,
   output logic              frm_drop,
   output logic              rd_req,
   output logic [AW-1:0]     rd_addr,
   input  logic              rd_valid,
   input  logic [31:0]       rd_data,
   output logic              cls_req,
   output logic [AW-1:0]     cls_addr,
   output logic [31:0]       cls_status,
   input  logic [NFLAG-1:0]  flag_clr,
   output logic [NFLAG-1:0]  flags,
   output logic [1:0]        run_state
);
   logic load_base, advance, ring_end, set_rbu, set_drop;
   logic [AW-1:0] cur_addr;
   logic unused_desc_bits;

   assign unused_desc_bits = ^rd_data[RING_END_BIT-1:0];
   assign rd_addr = cur_addr;

   rxring_addr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .base(cfg_base), .load_base(load_base),
      .advance(advance), .ring_end(ring_end), .cur_addr(cur_addr));

   rxring_fsm #(.AW(AW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .poll_demand(poll_demand),
      .frm_start(frm_start), .frm_buf_end(frm_buf_end), .frm_done(frm_done),
      .frm_status(frm_status), .rd_valid(rd_valid),
      .desc_own(rd_data[OWN_BIT]), .desc_end(rd_data[RING_END_BIT]),
      .cur_addr(cur_addr), .load_base(load_base), .advance(advance), .ring_end(ring_end),
      .set_rbu(set_rbu), .set_drop(set_drop), .rd_req(rd_req),
      .frm_accept(frm_accept), .frm_drop(frm_drop), .cls_req(cls_req),
      .cls_addr(cls_addr), .cls_status(cls_status), .run_state(run_state));

   rxring_flags #(.N(NFLAG)) u_flags (
      .clk(clk), .rst_n(rst_n), .set({set_drop, set_rbu}), .clr(flag_clr), .flags(flags));
endmodule

// File: tb/test_rxring_ctrl.sv
module test_rxring_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DB = 16;
   localparam int LAT = 2;
   localparam logic [AW-1:0] BASE = 32'h0000_0100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_start = 0, poll_demand = 0, frm_start = 0, frm_buf_end = 0, frm_done = 0;
   logic [29:0] frm_status = '0;
   logic rd_valid = 0;
   logic [31:0] rd_data = '0;
   logic [1:0] flag_clr = '0;
   logic frm_accept, frm_drop, rd_req, cls_req;
   logic [AW-1:0] rd_addr, cls_addr;
   logic [31:0] cls_status;
   logic [1:0] flags, run_state;

   int checks = 0, fails = 0;
   logic [31:0] mem [0:3];

   always #(CLK_PERIOD/2) clk = ~clk;

   rxring_ctrl #(.AW(AW), .DESC_BYTES(DB)) i_rxring_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_base(BASE),
      .poll_demand(poll_demand), .frm_start(frm_start), .frm_buf_end(frm_buf_end),
      .frm_done(frm_done), .frm_status(frm_status), .frm_accept(frm_accept),
      .frm_drop(frm_drop), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
      .rd_data(rd_data), .cls_req(cls_req), .cls_addr(cls_addr), .cls_status(cls_status),
      .flag_clr(flag_clr), .flags(flags), .run_state(run_state));

   // memory responder: answers each request LAT falling edges later
   int lat_cnt = 0;
   int rd_idx = 0;
   always @(negedge clk) begin
      rd_valid <= 1'b0;
      if (lat_cnt > 0) begin
         lat_cnt = lat_cnt - 1;
         if (lat_cnt == 0) begin rd_valid <= 1'b1; rd_data <= mem[rd_idx]; end
      end
      if (rst_n && rd_req) begin lat_cnt = LAT; rd_idx = int'((rd_addr - BASE) / DB); end
   end

   // behavioural reference model: phase 0 idle,1 waiting,2 holding,3 in frame,4 parked
   int ph = 0;
   bit m_pend, m_mid, m_park, m_end;
   logic [AW-1:0] m_addr;
   logic e_req, e_acc, e_drop, e_cls;
   logic [AW-1:0] e_caddr;
   logic [31:0] e_cstat;
   logic [1:0] e_flags, e_state;
   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_pend = 0; m_mid = 0; m_park = 0; m_end = 0; m_addr = '0;
         e_req = 0; e_acc = 0; e_drop = 0; e_cls = 0; e_caddr = '0; e_cstat = '0; e_flags = '0;
      end else begin
         logic [1:0] setf;
         setf = 2'b00; e_req = 0; e_acc = 0; e_drop = 0; e_cls = 0;
         if (ph == 0) begin
            if (cfg_start) begin m_addr = BASE; e_req = 1; ph = 1; m_pend = 0; m_mid = 0; m_park = 0; end
         end else if (ph == 1) begin
            if (frm_start) m_pend = 1;
            if (rd_valid) begin
               m_end = rd_data[30];
               if (rd_data[31]) begin
                  if (m_mid) ph = 3;
                  else if (m_pend) begin e_acc = 1; ph = 3; end
                  else ph = 2;
               end else begin
                  if (!m_park) setf[0] = 1;
                  if (m_pend || m_mid) begin e_drop = 1; setf[1] = 1; end
                  ph = 4;
               end
               m_pend = 0;
            end
         end else if (ph == 2) begin
            if (frm_start) begin e_acc = 1; ph = 3; end
            else if (!cfg_start) ph = 0;
         end else if (ph == 3) begin
            if (frm_done || frm_buf_end) begin
               e_cls = 1; e_caddr = m_addr; e_cstat = {1'b0, m_end, frm_status};
               m_addr = m_end ? BASE : m_addr + DB;
               m_park = 0; m_mid = !frm_done;
               if (frm_buf_end && !frm_done || cfg_start) begin e_req = 1; ph = 1; end
               else ph = 0;
            end
         end else begin
            if (frm_start || poll_demand) begin e_req = 1; ph = 1; m_park = 1; m_pend = frm_start; m_mid = 0; end
            else if (!cfg_start) ph = 0;
         end
         e_flags = (e_flags & ~flag_clr) | setf;
      end
      e_state = (ph == 0) ? 2'd0 : (ph == 4 || (ph == 1 && m_park)) ? 2'd2 : 2'd1;
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      chk("R2 rd_req", 64'(rd_req), 64'(e_req));
      if (e_req) chk("R6 rd_addr", 64'(rd_addr), 64'(m_addr));
      chk("R4 frm_accept", 64'(frm_accept), 64'(e_acc));
      chk("R8 frm_drop", 64'(frm_drop), 64'(e_drop));
      chk("R5 cls_req", 64'(cls_req), 64'(e_cls));
      if (e_cls) begin
         chk("R5 cls_addr", 64'(cls_addr), 64'(e_caddr));
         chk("R5 cls_status", 64'(cls_status), 64'(e_cstat));
      end
      chk("R12 flags", 64'(flags), 64'(e_flags));
      chk("R3 run_state", 64'(run_state), 64'(e_state));
   end

   task automatic idle(int n); repeat (n) @(negedge clk); endtask
   task automatic p_start;   @(negedge clk); frm_start = 1;   @(negedge clk); frm_start = 0;   endtask
   task automatic p_bufend;  @(negedge clk); frm_buf_end = 1; @(negedge clk); frm_buf_end = 0; endtask
   task automatic p_poll;    @(negedge clk); poll_demand = 1; @(negedge clk); poll_demand = 0; endtask
   task automatic p_clr;     @(negedge clk); flag_clr = 2'b11; @(negedge clk); flag_clr = 2'b00; endtask
   task automatic p_done(logic [29:0] st);
      @(negedge clk); frm_status = st; frm_done = 1; @(negedge clk); frm_done = 0;
   endtask

   bit finished = 0;
   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      mem[0] = 32'h8000_0000; mem[1] = 32'h8000_0000;
      mem[2] = 32'h8000_0000; mem[3] = 32'hC000_0000;
      idle(3); rst_n = 1; idle(2);
      chk("R1 state", 64'(run_state), 64'd0);  chk("R1 flags", 64'(flags), 64'd0);
      chk("R1 req", 64'({rd_req, cls_req, frm_accept, frm_drop}), 64'd0);
      p_poll(); idle(3);
      chk("R10 poll stopped", 64'(run_state), 64'd0);
      cfg_start = 1; idle(8);
      chk("R3 held", 64'(run_state), 64'd1);
      p_start(); idle(4); p_done(30'h0AB); idle(8);           // d0 -> d1
      p_start(); idle(3); p_bufend(); idle(8);                // d1 -> d2 mid-frame
      chk("R7 continue", 64'(run_state), 64'd1);
      p_done(30'h1234); idle(8);                              // d2 -> d3
      mem[0] = 32'h0000_0000;
      p_start(); idle(3); p_done(30'h3FFF_FFFF); idle(8);     // d3 wraps to d0 host-owned
      chk("R3 rbu", 64'(flags), 64'd1);
      p_start(); idle(8); p_start(); idle(8);
      p_clr(); idle(2); p_start(); idle(8);
      chk("R9 no rbu again", 64'(flags), 64'd2);
      chk("R8 stays suspended", 64'(run_state), 64'd2);
      p_poll(); idle(8);
      chk("R10 still host", 64'(run_state), 64'd2);
      mem[0] = 32'h8000_0000; p_poll(); idle(8);
      chk("R10 resumed", 64'(run_state), 64'd1);
      mem[1] = 32'h0000_0000;
      p_start(); idle(3); p_done(30'h55); idle(8);            // d0 -> d1 host
      mem[1] = 32'h8000_0000; mem[2] = 32'h0000_0000; p_clr(); idle(2);
      p_start(); idle(8);                                     // refetch d1, accept
      p_bufend(); idle(8);                                    // d2 host: drop
      chk("R7 drop suspend", 64'(flags), 64'd3);
      p_done(30'h77); idle(4);                                // ignored while suspended
      cfg_start = 0; idle(4);
      chk("R11 stop from suspend", 64'(run_state), 64'd0);
      cfg_start = 1; idle(8);                                 // restarts at base d0
      p_start(); cfg_start = 0; idle(3); p_poll(); idle(2); p_done(30'h99); idle(8);
      chk("R11 stopped after frame", 64'(run_state), 64'd0);
      p_poll(); idle(4);
      finished = 1;
      summary();
   end
endmodule